// File: doc/BRIEF.md
# Edge/Level Interrupt Controller with Vector Routing

The block gathers up to 64 synchronous interrupt request inputs. Each input is set up through a small register port for one of two trigger modes. In edge mode an input latches a pending request when it goes from low to high. In level mode the pending state follows the input. An input that is pending and unmasked is taken into service, and the block then raises one of its upstream lines. The line is chosen by that input's byte in a vector table.

Software handles an interrupt in three ways. It masks and unmasks inputs, and every mask change immediately re-evaluates delivery for the affected bits. It acknowledges edge requests by writing their bits to a clear word. It reads a status word that shows the in-service inputs that are not masked. Every 64-bit state register is reached as two 32-bit words. The vector table and a companion route table are reached a byte at a time.

Each clock applies all input changes first, one independent event per changed input. A register write is then evaluated against the result of those events. A bus-driven evaluation acts on only the lowest-numbered eligible input in the bits it affects.

Top module: `lvl_edge_intc`

## Requirements
- R1: When an input's bit in the trigger-mode word is 1 (edge mode), a 0→1 change of that input sets its pending bit. A 1→0 change leaves the pending bit set.
- R2: When an input's bit in the trigger-mode word is 0 (level mode), every change of that input copies the new level into its pending bit.
- R3: The block keeps a last-seen level for every input, and it follows the input each clock. An edge input therefore becomes pending again on each later rise.
- R4: An input that rises while pending and unmasked is put in service, and the line numbered by its vector byte goes high. Several inputs may change in the same clock. Each is then handled on its own, in ascending index order, and the highest-numbered input wins a line that two of them share.
- R5: An input that falls while in service and no longer pending leaves service, and its vector line goes low.
- R6: A mask write (word 0x020 low half, 0x024 high half) that unmasks bits puts the lowest-numbered unmasked bit that is pending into service and drives its line high. Newly masked bits take the lowest-numbered one that is in service but not pending out of service and drive its line low. The mask resets to all ones.
- R7: A write to the clear word (0x080 low, 0x084 high) does nothing unless at least one written bit is in edge mode. If one is, the write clears pending for all written bits. It then takes the lowest-numbered written in-service bit out of service, driving its line low, and finally clears in-service for all written bits.
- R8: Word 0x0A0/0x0A4 reads in-service AND NOT mask. Word 0x000 reads the ID_WORD parameter. Word 0x004 reads NUM_IN−1 in bits 31:16 and VERSION in bits 15:0.
- R9: The trigger-mode word is at 0x060/0x064. Writing either half of the mask or the trigger-mode word leaves the other half unchanged. Bit 2 of the address selects the upper half.
- R10: The vector table (0x200+n) and the route table (0x100+n) hold one byte per input. They are written from write-data bits 7:0 and read back in bits 7:0. A vector value of NUM_OUT or above drives no line.
- R11: After reset the route bytes are 1. The vector bytes, trigger modes, pending, in-service, last-seen levels and lines are all 0.
- R12: Unmapped offsets, the auto-control words 0x0C0–0x0CC and the clear words read as zero. Writes to unmapped offsets and to the auto-control words change no state.
- R13: Read data appears one clock after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Synchronous interrupt request inputs |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_OUT | Upstream interrupt lines |

## Verification
The bench builds the block with NUM_IN=64 and NUM_OUT=16. With that setting, every vector byte from 16 to 255 is an unreachable line, and the out-of-range case becomes an ordinary stimulus. Sixteen lines shared by 64 inputs also make two inputs mapping to one line a frequent event. This brings within reach the ordering of a serve and a retire on one line in a single clock, and a retire that drops a line another input still holds. Both halves of every 64-bit word are in play, since the high inputs exist.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int ADDR_W = 12;

    localparam logic [11:0] A_ID_LO   = 12'h000;
    localparam logic [11:0] A_ID_HI   = 12'h004;
    localparam logic [11:0] A_MASK_LO = 12'h020;
    localparam logic [11:0] A_MASK_HI = 12'h024;
    localparam logic [11:0] A_TRIG_LO = 12'h060;
    localparam logic [11:0] A_TRIG_HI = 12'h064;
    localparam logic [11:0] A_CLR_LO  = 12'h080;
    localparam logic [11:0] A_STAT_LO = 12'h0A0;
    localparam logic [11:0] A_STAT_HI = 12'h0A4;

    localparam logic [5:0] PAGE_ROUTE = 6'h04;
    localparam logic [5:0] PAGE_VEC   = 6'h08;

    typedef enum logic [1:0] {
        BUS_NONE,
        BUS_MASK,
        BUS_TRIG,
        BUS_CLEAR
    } bus_op_e;

    function automatic logic [63:0] merge_half(input logic [63:0] old,
                                               input logic [31:0] d,
                                               input logic        hi);
        return hi ? {d, old[31:0]} : {old[63:32], d};
    endfunction
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_table.sv
module pic_table #(
    parameter int         N    = 64,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [5:0]     idx,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    output logic [N*8-1:0] flat
);
    logic [7:0] ent [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= INIT;
        end else if (we && (int'(idx) < N)) begin
            ent[int'(idx)] <= wdata;
        end
    end

    assign rdata = (int'(idx) < N) ? ent[int'(idx)] : 8'h00;

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign flat[g*8 +: 8] = ent[g];
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int NUM_IN  = 64,
    parameter int NUM_OUT = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IN-1:0]   irq_in,
    input  bus_op_e             op,
    input  logic                hi,
    input  logic [31:0]         wdata,
    input  logic [NUM_IN*8-1:0] vec_flat,
    output logic [63:0]         mask_q,
    output logic [63:0]         trig_q,
    output logic [63:0]         isr_q,
    output logic [63:0]         pend_q,
    output logic [63:0]         last_q,
    output logic [NUM_OUT-1:0]  lines_q
);
    localparam logic [63:0] VALID = {64{1'b1}} >> (64 - NUM_IN);

    logic [511:0] vec_all;
    logic [63:0]  in64, chg, rise, fall, lvl_chg;
    logic [63:0]  pend1, isr1, serve, retire;
    logic [255:0] ln1, ln2;
    logic [63:0]  wd64, mask_new, unmask, newmask, raise_req, lower_req;
    logic [63:0]  pend_d, isr_d, trig_d;
    logic         clr_act, r_hit, l_hit;
    logic [5:0]   r_idx, l_idx;

    assign vec_all = 512'(vec_flat);
    assign in64    = 64'(irq_in);
    assign chg     = (in64 ^ last_q) & VALID;
    assign rise    = chg & in64;
    assign fall    = chg & ~in64;
    assign lvl_chg = chg & ~trig_q;

    // input events: one independent event per changed input
    assign pend1  = (pend_q & ~lvl_chg) | (lvl_chg & in64) | (rise & trig_q);
    assign serve  = rise & pend1 & ~mask_q;
    assign retire = fall & isr_q & ~pend1;
    assign isr1   = (isr_q | serve) & ~retire;

    always_comb begin
        ln1 = 256'(lines_q);
        for (int i = 0; i < 64; i++) begin
            if (serve[i])       ln1[vec_all[i*8 +: 8]] = 1'b1;
            else if (retire[i]) ln1[vec_all[i*8 +: 8]] = 1'b0;
        end
    end

    // bus event evaluated after the input events
    assign wd64      = hi ? {wdata, 32'h0} : {32'h0, wdata};
    assign mask_new  = (op == BUS_MASK) ? merge_half(mask_q, wdata, hi) : mask_q;
    assign unmask    = mask_q & ~mask_new;
    assign newmask   = ~mask_q & mask_new;
    assign clr_act   = (op == BUS_CLEAR) && |(trig_q & wd64 & VALID);
    assign raise_req = unmask & pend1;
    assign lower_req = clr_act ? (wd64 & isr1) : (newmask & isr1 & ~pend1);

    pic_prio #(.W(64)) u_raise (.req(raise_req), .hit(r_hit), .idx(r_idx));
    pic_prio #(.W(64)) u_lower (.req(lower_req), .hit(l_hit), .idx(l_idx));

    always_comb begin
        pend_d = clr_act ? (pend1 & ~wd64) : pend1;
        isr_d  = isr1;
        ln2    = ln1;
        if (r_hit) begin
            isr_d[r_idx]                  = 1'b1;
            ln2[vec_all[{r_idx, 3'b000} +: 8]] = 1'b1;
        end
        if (l_hit) begin
            isr_d[l_idx]                  = 1'b0;
            ln2[vec_all[{l_idx, 3'b000} +: 8]] = 1'b0;
        end
        if (clr_act) isr_d = isr_d & ~wd64;
        trig_d = (op == BUS_TRIG) ? merge_half(trig_q, wdata, hi) : trig_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            trig_q  <= '0;
            isr_q   <= '0;
            pend_q  <= '0;
            last_q  <= '0;
            lines_q <= '0;
        end else begin
            mask_q  <= mask_new;
            trig_q  <= trig_d;
            isr_q   <= isr_d;
            pend_q  <= pend_d;
            last_q  <= in64 & VALID;
            lines_q <= ln2[NUM_OUT-1:0];
        end
    end
endmodule

// File: rtl/lvl_edge_intc.sv
module lvl_edge_intc
    import pic_pkg::*;
#(
    parameter int          NUM_IN  = 64,
    parameter int          NUM_OUT = 64,
    parameter logic [15:0] VERSION = 16'h0001,
    parameter logic [31:0] ID_WORD = 32'h0700_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IN-1:0]  irq_in,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [11:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_OUT-1:0] irq_out
);
    localparam logic [31:0] ID_HI_VAL = {16'(NUM_IN - 1), VERSION};

    logic          wr, rd, aligned, hi, vec_we, route_we;
    logic [11:0]   wbase;
    logic [5:0]    page;
    bus_op_e       op;
    logic [63:0]   mask_q, trig_q, isr_q, pend_q, last_q, stat;
    logic [7:0]    vec_rd, route_rd;
    logic [NUM_IN*8-1:0] vec_flat, route_flat;
    logic [31:0]   rd_d;

    assign wr       = reg_valid & reg_write;
    assign rd       = reg_valid & ~reg_write;
    assign aligned  = (reg_addr[1:0] == 2'b00);
    assign hi       = reg_addr[2];
    assign wbase    = {reg_addr[11:3], 3'b000};
    assign page     = reg_addr[11:6];
    assign vec_we   = wr && (page == PAGE_VEC);
    assign route_we = wr && (page == PAGE_ROUTE);
    assign stat     = isr_q & ~mask_q;

    always_comb begin
        op = BUS_NONE;
        if (wr && aligned) begin
            unique case (wbase)
                A_MASK_LO: op = BUS_MASK;
                A_TRIG_LO: op = BUS_TRIG;
                A_CLR_LO:  op = BUS_CLEAR;
                default:   op = BUS_NONE;
            endcase
        end
    end

    pic_table #(.N(NUM_IN), .INIT(8'h00)) u_vec (
        .clk(clk), .rst(rst), .we(vec_we), .idx(reg_addr[5:0]),
        .wdata(reg_wdata[7:0]), .rdata(vec_rd), .flat(vec_flat));

    pic_table #(.N(NUM_IN), .INIT(8'h01)) u_route (
        .clk(clk), .rst(rst), .we(route_we), .idx(reg_addr[5:0]),
        .wdata(reg_wdata[7:0]), .rdata(route_rd), .flat(route_flat));

    pic_core #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_core (
        .clk(clk), .rst(rst), .irq_in(irq_in), .op(op), .hi(hi),
        .wdata(reg_wdata), .vec_flat(vec_flat), .mask_q(mask_q),
        .trig_q(trig_q), .isr_q(isr_q), .pend_q(pend_q), .last_q(last_q),
        .lines_q(irq_out));

    always_comb begin
        rd_d = '0;
        if (page == PAGE_VEC) begin
            rd_d = {24'h0, vec_rd};
        end else if (page == PAGE_ROUTE) begin
            rd_d = {24'h0, route_rd};
        end else if (aligned) begin
            unique case (reg_addr)
                A_ID_LO:   rd_d = ID_WORD;
                A_ID_HI:   rd_d = ID_HI_VAL;
                A_MASK_LO: rd_d = mask_q[31:0];
                A_MASK_HI: rd_d = mask_q[63:32];
                A_TRIG_LO: rd_d = trig_q[31:0];
                A_TRIG_HI: rd_d = trig_q[63:32];
                A_STAT_LO: rd_d = stat[31:0];
                A_STAT_HI: rd_d = stat[63:32];
                default:   rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     reg_rdata <= '0;
        else if (rd) reg_rdata <= rd_d;
    end
endmodule

// File: rtl/pic_chk.sv
module pic_chk
    import pic_pkg::*;
#(
    parameter int NUM_IN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_IN-1:0] irq_in,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [11:0]       reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [63:0]       mask_q,
    input logic [63:0]       trig_q,
    input logic [63:0]       isr_q,
    input logic [63:0]       pend_q,
    input logic [63:0]       last_q
);
    logic [63:0] in64, wd64;
    logic        mask_wr, clr_wr;

    assign in64    = 64'(irq_in);
    assign wd64    = reg_addr[2] ? {reg_wdata, 32'h0} : {32'h0, reg_wdata};
    assign mask_wr = reg_valid && reg_write && (reg_addr[1:0] == 2'b00)
                     && (reg_addr[11:3] == A_MASK_LO[11:3]);
    assign clr_wr  = reg_valid && reg_write && (reg_addr[1:0] == 2'b00)
                     && (reg_addr[11:3] == A_CLR_LO[11:3]);

    AST_MASK_RESET_ONES: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == '1)); // R6

    AST_LAST_TRACKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (last_q == $past(in64))); // R3

    AST_NEW_SERVICE_PENDING: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((isr_q & ~$past(isr_q) & ~pend_q) == 64'h0)); // R4

    AST_NEW_SERVICE_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> ((isr_q & ~$past(isr_q) & mask_q) == 64'h0)); // R4

    AST_ONE_PER_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && (in64 == last_q)) |=> ($countones(isr_q & ~$past(isr_q)) <= 1)); // R6

    AST_CLEAR_DROPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && |(trig_q & wd64)) |=> (((pend_q | isr_q) & $past(wd64)) == 64'h0)); // R7
endmodule

bind lvl_edge_intc pic_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mask_q(mask_q), .trig_q(trig_q), .isr_q(isr_q), .pend_q(pend_q),
    .last_q(last_q));

// File: tb/sim_lvl_edge_intc.sv
module sim_lvl_edge_intc;
    localparam int          NI  = 64;
    localparam int          NO  = 16;
    localparam logic [15:0] VER = 16'h0001;
    localparam logic [31:0] IDW = 32'h0700_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] irq_in = '0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NO-1:0] irq_out;

    always #2 clk = ~clk;

    lvl_edge_intc #(.NUM_IN(NI), .NUM_OUT(NO), .VERSION(VER), .ID_WORD(IDW)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_valid(reg_valid),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out));

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R11";

    logic [63:0]  m_mask, m_trig, m_pend, m_isr, m_last;
    logic [255:0] m_lines;
    int           m_vec [64];
    int           m_route [64];
    logic [31:0]  exp_rd;
    bit           exp_rd_v;

    function automatic int lowest(input logic [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        m_mask = '1; m_trig = '0; m_pend = '0; m_isr = '0; m_last = '0;
        m_lines = '0; exp_rd_v = 0;
        for (int i = 0; i < 64; i++) begin m_vec[i] = 0; m_route[i] = 1; end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [63:0] st;
        st = m_isr & ~m_mask;
        if (a[11:6] == 6'h08) return 32'(m_vec[a[5:0]]);
        if (a[11:6] == 6'h04) return 32'(m_route[a[5:0]]);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a)
            12'h000: return IDW;
            12'h004: return {16'(NI - 1), VER};
            12'h020: return m_mask[31:0];
            12'h024: return m_mask[63:32];
            12'h060: return m_trig[31:0];
            12'h064: return m_trig[63:32];
            12'h0A0: return st[31:0];
            12'h0A4: return st[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        logic [63:0] d64, old;
        int k;
        d64 = a[2] ? {d, 32'h0} : {32'h0, d};
        if (a[11:6] == 6'h08) m_vec[a[5:0]] = int'(d[7:0]);
        else if (a[11:6] == 6'h04) m_route[a[5:0]] = int'(d[7:0]);
        else if (a[1:0] == 2'b00) begin
            case ({a[11:3], 3'b000})
                12'h020: begin
                    old = m_mask;
                    if (a[2]) m_mask[63:32] = d; else m_mask[31:0] = d;
                    k = lowest(old & ~m_mask & m_pend);
                    if (k >= 0) begin m_isr[k] = 1'b1; m_lines[m_vec[k]] = 1'b1; end
                    k = lowest(~old & m_mask & m_isr & ~m_pend);
                    if (k >= 0) begin m_isr[k] = 1'b0; m_lines[m_vec[k]] = 1'b0; end
                end
                12'h060: if (a[2]) m_trig[63:32] = d; else m_trig[31:0] = d;
                12'h080: if (|(m_trig & d64)) begin
                    m_pend = m_pend & ~d64;
                    k = lowest(d64 & m_isr);
                    if (k >= 0) begin m_isr[k] = 1'b0; m_lines[m_vec[k]] = 1'b0; end
                    m_isr = m_isr & ~d64;
                end
                default: ;
            endcase
        end
    endtask

    task automatic model_step();
        logic [63:0] in64;
        in64 = 64'(irq_in);
        exp_rd_v = reg_valid && !reg_write;
        if (exp_rd_v) exp_rd = model_read(reg_addr);
        for (int i = 0; i < 64; i++) begin
            if (in64[i] != m_last[i]) begin
                m_last[i] = in64[i];
                if (m_trig[i]) begin
                    if (in64[i]) m_pend[i] = 1'b1;
                end else m_pend[i] = in64[i];
                if (in64[i]) begin
                    if (m_pend[i] && !m_mask[i]) begin m_isr[i] = 1'b1; m_lines[m_vec[i]] = 1'b1; end
                end else if (m_isr[i] && !m_pend[i]) begin
                    m_isr[i] = 1'b0; m_lines[m_vec[i]] = 1'b0;
                end
            end
        end
        if (reg_valid && reg_write) model_write(reg_addr, reg_wdata);
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        checks++;
        if (irq_out !== m_lines[NO-1:0]) begin
            errors++;
            $display("FAIL %s irq_out actual=%h expected=%h", req, irq_out, m_lines[NO-1:0]);
        end
        if (exp_rd_v) begin
            checks++;
            if (reg_rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s model read actual=%h expected=%h", req, reg_rdata, exp_rd);
            end
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] v);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        cyc();
        reg_valid = 1'b0;
        checks++;
        if (reg_rdata !== v) begin
            errors++;
            $display("FAIL %s read %h actual=%h expected=%h", req, a, reg_rdata, v);
        end
    endtask

    task automatic setin(input int n, input logic v);
        irq_in[n] = v;
        cyc();
    endtask

    task automatic expect_line(input int n, input logic v);
        checks++;
        if (irq_out[n] !== v) begin
            errors++;
            $display("FAIL %s line %0d actual=%b expected=%b", req, n, irq_out[n], v);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        req = "R11";
        expect_rd(12'h020, 32'hFFFF_FFFF);
        expect_rd(12'h024, 32'hFFFF_FFFF);
        expect_rd(12'h060, 32'h0);
        expect_rd(12'h104, 32'h1);
        expect_rd(12'h205, 32'h0);
        expect_rd(12'h0A0, 32'h0);
        expect_line(0, 1'b0);

        req = "R8";
        expect_rd(12'h000, IDW);
        expect_rd(12'h004, 32'h003F_0001);

        req = "R10";
        for (int i = 0; i < 16; i++) wr(12'h200 + 12'(i), 32'(i));
        wr(12'h210, 32'd5);
        wr(12'h228, 32'd200);
        wr(12'h229, 32'd3);
        wr(12'h209, 32'd9);
        wr(12'h208, 32'd9);
        wr(12'h13F, 32'h0000_00A5);
        expect_rd(12'h13F, 32'h0000_00A5);
        wr(12'h20A, 32'h0000_1234);
        expect_rd(12'h20A, 32'h0000_0034);
        wr(12'h20A, 32'd10);

        req = "R2";
        wr(12'h020, 32'hFFFF_FFFE);
        setin(0, 1'b1);
        expect_line(0, 1'b1);
        req = "R8";
        expect_rd(12'h0A0, 32'h1);
        req = "R5";
        setin(0, 1'b0);
        expect_line(0, 1'b0);
        expect_rd(12'h0A0, 32'h0);

        req = "R6";
        setin(1, 1'b1);
        expect_line(1, 1'b0);
        setin(2, 1'b1);
        wr(12'h020, 32'hFFFF_FFF8);
        expect_line(1, 1'b1);
        expect_line(2, 1'b0);
        expect_rd(12'h0A0, 32'h2);
        wr(12'h020, 32'hFFFF_FFFA);
        expect_line(1, 1'b1);
        expect_rd(12'h0A0, 32'h0);
        req = "R5";
        setin(1, 1'b0);
        expect_line(1, 1'b0);
        setin(2, 1'b0);

        req = "R1";
        wr(12'h060, 32'h0000_00F0);
        wr(12'h020, 32'hFFFF_FFCA);
        setin(4, 1'b1);
        expect_line(4, 1'b1);
        setin(4, 1'b0);
        expect_line(4, 1'b1);
        expect_rd(12'h0A0, 32'h10);

        req = "R7";
        setin(0, 1'b1);
        wr(12'h080, 32'h1);
        expect_line(0, 1'b1);
        expect_rd(12'h0A0, 32'h11);
        wr(12'h080, 32'h10);
        expect_line(4, 1'b0);
        expect_line(0, 1'b1);
        expect_rd(12'h0A0, 32'h1);
        req = "R3";
        setin(4, 1'b1);
        expect_line(4, 1'b1);
        setin(4, 1'b0);
        req = "R7";
        wr(12'h080, 32'h11);
        expect_line(0, 1'b0);
        expect_line(4, 1'b1);
        expect_rd(12'h0A0, 32'h0);
        expect_rd(12'h080, 32'h0);

        req = "R9";
        wr(12'h024, 32'hFFFF_FCFF);
        expect_rd(12'h020, 32'hFFFF_FFCA);
        wr(12'h064, 32'h0);
        expect_rd(12'h060, 32'h0000_00F0);
        expect_rd(12'h024, 32'hFFFF_FCFF);

        req = "R10";
        setin(40, 1'b1);
        expect_rd(12'h0A4, 32'h100);
        setin(41, 1'b1);
        expect_line(3, 1'b1);

        req = "R4";
        wr(12'h020, 32'hFFFF_FCCA);
        irq_in[8] = 1'b1;
        irq_in[9] = 1'b1;
        cyc();
        expect_line(9, 1'b1);
        setin(8, 1'b0);
        expect_line(9, 1'b0);
        expect_rd(12'h0A0, 32'h200);

        req = "R12";
        wr(12'h0C0, 32'hFFFF_FFFF);
        wr(12'h0CC, 32'hFFFF_FFFF);
        expect_rd(12'h0C0, 32'h0);
        wr(12'h7F0, 32'hFFFF_FFFF);
        expect_rd(12'h7F0, 32'h0);
        expect_rd(12'h020, 32'hFFFF_FCCA);
        expect_rd(12'h060, 32'h0000_00F0);

        req = "R13";
        expect_rd(12'h004, 32'h003F_0001);
        cyc();
        checks++;
        if (reg_rdata !== 32'h003F_0001) begin
            errors++;
            $display("FAIL R13 held read actual=%h expected=%h", reg_rdata, 32'h003F_0001);
        end

        req = "R4";
        for (int n = 0; n < 3000; n++) begin
            int sel;
            sel = int'($urandom_range(0, 15));
            if ($urandom_range(0, 2) == 0) irq_in[$urandom_range(0, NI - 1)] ^= 1'b1;
            reg_valid = 1'b0;
            case (sel)
                0, 1: begin reg_valid = 1; reg_write = 1; reg_addr = {9'h004, 1'($urandom_range(0, 1)), 2'b00}; reg_wdata = $urandom; end
                2:    begin reg_valid = 1; reg_write = 1; reg_addr = {9'h00C, 1'($urandom_range(0, 1)), 2'b00}; reg_wdata = $urandom; end
                3, 4: begin reg_valid = 1; reg_write = 1; reg_addr = {9'h010, 1'($urandom_range(0, 1)), 2'b00}; reg_wdata = $urandom; end
                5:    begin reg_valid = 1; reg_write = 1; reg_addr = 12'h200 + 12'($urandom_range(0, 63)); reg_wdata = $urandom_range(0, 20); end
                6, 7: begin reg_valid = 1; reg_write = 0; reg_addr = {9'h014, 1'($urandom_range(0, 1)), 2'b00}; end
                default: ;
            endcase
            cyc();
            reg_valid = 1'b0; reg_write = 1'b0;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule